// File: doc/BRIEF.md
# Single-Register Access Channel

This block turns host register writes into one-at-a-time 16-bit read and write transfers toward a remote device that sits behind a serial link. The host places a 32-bit command word into the command register. The block latches the command, asks a back-end serial engine for the link, waits for the engine to report completion, and then shows the outcome in a status word. The host polls that status word to follow the transfer and to collect read data.

A read is not finished when its data arrives. The channel holds the returned halfword and stays parked until the host writes a 1 to the valid-clear register. Only when the channel is idle again does it take a new command. A command that arrives while a transfer is still in flight is dropped and recorded in a sticky error flag. A channel enable input decides whether commands are accepted in idle. An init-done flag that the host can write is shown in the status word, so that software can see whether link bring-up has finished.

The back-end engine is represented by a request/grant/done port. The physical serial protocol is outside this block.

Top module: `reg_access_chan`

## Requirements
- R1: A command word is decoded as follows: bit 31 selects the direction (1 = write, 0 = read), bits 30:16 hold a halfword index, and bits 15:0 hold the write data. The back end receives the byte address index*2 on `be_addr`, the direction on `be_write`, and the data on `be_wdata`. All three stay constant from acceptance until the channel is idle again.
- R2: There are four host registers at word offsets 0 = command (write), 1 = status (read), 2 = valid-clear (write), 3 = control. The status word carries the last read data in bits 15:0, the state code in bits 18:16, the `be_idle` input in bit 20, init-done in bit 21 and the sticky error in bit 22. All other bits read as 0. A read of offset 3 returns {error, init-done} in bits 1:0. Offsets 0 and 2 read as 0.
- R3: The state codes are idle = 0, request = 2, wait-for-data = 4 and wait-for-valid-clear = 6. After reset the channel is idle, with read data 0, error 0 and init-done 0.
- R4: An accepted command puts the channel in request in the next cycle. `be_req` is high in request and stays high until `be_gnt` is seen. The cycle after the grant, the channel is in wait-for-data.
- R5: A write transfer returns to idle on `be_done` and never enters wait-for-valid-clear.
- R6: A read transfer captures `be_rdata` on `be_done` and moves to wait-for-valid-clear. It stays there until offset 2 is written with bit 0 = 1. A valid-clear write with bit 0 = 0, or a valid-clear write in any other state, has no effect.
- R7: A command written while the channel is not idle is dropped: the transfer in flight keeps its state and fields, and no second transfer starts. The drop sets the error flag, which stays set until the control register is written with bit 1 = 1.
- R8: While `chan_en` is low, a command written in idle is ignored. The channel stays idle and the error flag is not set.
- R9: Bit 0 of a control write sets or clears init-done, and init-done is visible in status bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Allows commands to be accepted in idle |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_sel | input | 2 | Word offset of the host write |
| host_wr_data | input | 32 | Host write data |
| host_rd_sel | input | 2 | Word offset of the host read |
| host_rd_data | output | 32 | Host read data (combinational) |
| be_req | output | 1 | Request toward the back-end engine |
| be_write | output | 1 | Direction of the current transfer |
| be_addr | output | 16 | Byte address of the current transfer |
| be_wdata | output | 16 | Write data of the current transfer |
| be_gnt | input | 1 | Back end has taken the request |
| be_done | input | 1 | Back end has finished the transfer |
| be_rdata | input | 16 | Read data, valid with `be_done` |
| be_idle | input | 1 | Back end reports idle |

## Verification
The hardest case to reach from the ports is a command that collides with a transfer already in flight. A legal host waits for idle, so in normal use the channel never sees such a command. The bench makes its back-end stub slow down on purpose: it stretches the done delay so that the channel sits in wait-for-data for many cycles, and it injects a second command during that window. It then reads back both target halfwords to show that the first transfer finished untouched and that the dropped write never reached the device. The same injection is repeated while a read is parked in wait-for-valid-clear.

// File: rtl/rac_pkg.sv
`timescale 1ns/1ps
package rac_pkg;
    parameter int DATA_W  = 16;
    parameter int IDX_W   = 15;
    parameter int WORD_W  = 32;
    parameter int SEL_W   = 2;

    localparam int BADDR_W   = IDX_W + 1;
    localparam int WFLAG_BIT = WORD_W - 1;
    localparam int ST_W      = 3;
    localparam int ST_LSB    = DATA_W;
    localparam int SYNC_BIT  = 20;
    localparam int INIT_BIT  = 21;
    localparam int ERR_BIT   = 22;

    localparam logic [SEL_W-1:0] OFS_CMD  = SEL_W'(0);
    localparam logic [SEL_W-1:0] OFS_STAT = SEL_W'(1);
    localparam logic [SEL_W-1:0] OFS_VCLR = SEL_W'(2);
    localparam logic [SEL_W-1:0] OFS_CTRL = SEL_W'(3);

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd2,
        ST_WDATA = 3'd4,
        ST_WVCLR = 3'd6
    } xfer_st_e;

    typedef struct packed {
        logic              wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } cmd_t;
endpackage

// File: rtl/rac_host_regs.sv
`timescale 1ns/1ps
module rac_host_regs
    import rac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              reject,
    output logic              cmd_push,
    output cmd_t              cmd,
    output logic              vclr_push,
    output logic              init_done,
    output logic              err
);
    typedef struct packed {
        logic init;
        logic err;
    } regs_t;

    regs_t r_q, r_d;
    logic  ctrl_wr;

    always_comb begin
        cmd_push  = wr_en && (wr_sel == OFS_CMD);
        vclr_push = wr_en && (wr_sel == OFS_VCLR) && wr_data[0];
        ctrl_wr   = wr_en && (wr_sel == OFS_CTRL);
        cmd.wr    = wr_data[WFLAG_BIT];
        cmd.idx   = wr_data[WFLAG_BIT-1 -: IDX_W];
        cmd.wdata = wr_data[DATA_W-1:0];

        r_d = r_q;
        if (ctrl_wr) begin
            r_d.init = wr_data[0];
            if (wr_data[1]) r_d.err = 1'b0;
        end
        if (reject) r_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign init_done = r_q.init;
    assign err       = r_q.err;

    // R7: a dropped command raises the error flag in the next cycle
    a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> err);

    // R7: the flag only falls through a control write with bit 1 set
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(ctrl_wr && wr_data[1])) |=> err);

    // R9: init-done follows bit 0 of a control write
    a_r9_init_follow: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (init_done == $past(wr_data[0])));
endmodule

// File: rtl/rac_xfer_fsm.sv
`timescale 1ns/1ps
module rac_xfer_fsm
    import rac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chan_en,
    input  logic               cmd_push,
    input  cmd_t               cmd,
    input  logic               vclr_push,
    input  logic               be_gnt,
    input  logic               be_done,
    input  logic [DATA_W-1:0]  be_rdata,
    output xfer_st_e           st,
    output logic [DATA_W-1:0]  rdata,
    output logic               reject,
    output logic               be_req,
    output logic               be_write,
    output logic [BADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0]  be_wdata
);
    typedef struct packed {
        xfer_st_e          st;
        cmd_t              cur;
        logic [DATA_W-1:0] rdata;
    } fsm_t;

    fsm_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_push && chan_en) begin
                    s_d.st  = ST_REQ;
                    s_d.cur = cmd;
                end
            end
            ST_REQ: begin
                if (be_gnt) s_d.st = ST_WDATA;
            end
            ST_WDATA: begin
                if (be_done) begin
                    if (s_q.cur.wr) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.st    = ST_WVCLR;
                        s_d.rdata = be_rdata;
                    end
                end
            end
            ST_WVCLR: begin
                if (vclr_push) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, cur: '0, rdata: '0};
        else        s_q <= s_d;
    end

    assign st       = s_q.st;
    assign rdata    = s_q.rdata;
    assign reject   = cmd_push && (s_q.st != ST_IDLE);
    assign be_req   = (s_q.st == ST_REQ);
    assign be_write = s_q.cur.wr;
    assign be_addr  = {s_q.cur.idx, 1'b0};
    assign be_wdata = s_q.cur.wdata;

    // R4: an ungranted request stays up
    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_gnt) |=> be_req);

    // R4: a grant moves the channel to wait-for-data
    a_r4_gnt_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_gnt) |=> (st == ST_WDATA));

    // R1: transfer fields do not move while a transfer is open
    a_r1_fields_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> ($stable(be_addr) && $stable(be_wdata) && $stable(be_write)));

    // R5: a finished write never parks
    a_r5_write_no_park: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WDATA && be_done && be_write) |=> (st == ST_IDLE));

    // R6: parked until a valid-clear with bit 0 set
    a_r6_park: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WVCLR && !vclr_push) |=> (st == ST_WVCLR));

    // R6: returned data is held while parked and when leaving
    a_r6_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WVCLR) |=> $stable(rdata));

    // R8: with the channel disabled, idle stays idle
    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !chan_en) |=> (st == ST_IDLE));
endmodule

// File: rtl/rac_readback.sv
`timescale 1ns/1ps
module rac_readback
    import rac_pkg::*;
(
    input  logic [SEL_W-1:0]  rd_sel,
    input  xfer_st_e          st,
    input  logic [DATA_W-1:0] rdata,
    input  logic              be_idle,
    input  logic              init_done,
    input  logic              err,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] stat_word;
    logic [WORD_W-1:0] ctrl_word;

    always_comb begin
        stat_word                  = '0;
        stat_word[DATA_W-1:0]      = rdata;
        stat_word[ST_LSB +: ST_W]  = st;
        stat_word[SYNC_BIT]        = be_idle;
        stat_word[INIT_BIT]        = init_done;
        stat_word[ERR_BIT]         = err;

        ctrl_word    = '0;
        ctrl_word[0] = init_done;
        ctrl_word[1] = err;

        unique case (rd_sel)
            OFS_STAT: rd_data = stat_word;
            OFS_CTRL: rd_data = ctrl_word;
            default:  rd_data = '0;
        endcase
    end

    // R2: state field always carries a legal code
    always_comb begin
        a_r2_state_code: assert (stat_word[ST_LSB] == 1'b0);
    end
endmodule

// File: rtl/reg_access_chan.sv
`timescale 1ns/1ps
module reg_access_chan
    import rac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chan_en,
    input  logic               host_wr_en,
    input  logic [SEL_W-1:0]   host_wr_sel,
    input  logic [WORD_W-1:0]  host_wr_data,
    input  logic [SEL_W-1:0]   host_rd_sel,
    output logic [WORD_W-1:0]  host_rd_data,
    output logic               be_req,
    output logic               be_write,
    output logic [BADDR_W-1:0] be_addr,
    output logic [DATA_W-1:0]  be_wdata,
    input  logic               be_gnt,
    input  logic               be_done,
    input  logic [DATA_W-1:0]  be_rdata,
    input  logic               be_idle
);
    logic              cmd_push;
    cmd_t              cmd;
    logic              vclr_push;
    logic              init_done;
    logic              err;
    logic              reject;
    xfer_st_e          st;
    logic [DATA_W-1:0] rdata;

    rac_host_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr_en),
        .wr_sel    (host_wr_sel),
        .wr_data   (host_wr_data),
        .reject    (reject),
        .cmd_push  (cmd_push),
        .cmd       (cmd),
        .vclr_push (vclr_push),
        .init_done (init_done),
        .err       (err)
    );

    rac_xfer_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .cmd_push  (cmd_push),
        .cmd       (cmd),
        .vclr_push (vclr_push),
        .be_gnt    (be_gnt),
        .be_done   (be_done),
        .be_rdata  (be_rdata),
        .st        (st),
        .rdata     (rdata),
        .reject    (reject),
        .be_req    (be_req),
        .be_write  (be_write),
        .be_addr   (be_addr),
        .be_wdata  (be_wdata)
    );

    rac_readback u_rb (
        .rd_sel    (host_rd_sel),
        .st        (st),
        .rdata     (rdata),
        .be_idle   (be_idle),
        .init_done (init_done),
        .err       (err),
        .rd_data   (host_rd_data)
    );

    // R3: idle right after reset
    a_r3_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (st == ST_IDLE));
endmodule

// File: tb/reg_access_chan_bench.sv
`timescale 1ns/1ps
module reg_access_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        chan_en;
    logic        host_wr_en;
    logic [1:0]  host_wr_sel;
    logic [31:0] host_wr_data;
    logic [1:0]  host_rd_sel;
    logic [31:0] host_rd_data;
    logic        be_req, be_write;
    logic [15:0] be_addr, be_wdata;
    logic        be_gnt, be_done;
    logic [15:0] be_rdata;
    logic        be_idle;

    int n_chk = 0;
    int n_err = 0;
    int gnt_dly = 1;
    int done_dly = 2;

    typedef struct {
        bit          w;
        logic [15:0] a;
        logic [15:0] d;
    } exp_t;
    exp_t exp_q[$];

    logic [15:0] dev_mem [256];
    logic [15:0] ref_mem [256];

    always #2 clk = ~clk;

    reg_access_chan u_reg_access_chan (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel), .host_wr_data(host_wr_data),
        .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
        .be_req(be_req), .be_write(be_write), .be_addr(be_addr), .be_wdata(be_wdata),
        .be_gnt(be_gnt), .be_done(be_done), .be_rdata(be_rdata), .be_idle(be_idle)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // back-end stub and scoreboard monitor
    int          ph = 0;
    int          cnt = 0;
    bit          cap_w;
    logic [15:0] cap_a, cap_d;
    always @(negedge clk) begin
        be_gnt  = 1'b0;
        be_done = 1'b0;
        if (!rst_n) begin
            ph = 0;
        end else begin
            case (ph)
                0: if (be_req) begin cnt = gnt_dly; ph = 1; end
                1: begin
                    if (cnt == 0) begin
                        be_gnt = 1'b1;
                        cap_w = be_write; cap_a = be_addr; cap_d = be_wdata;
                        if (exp_q.size() == 0) begin
                            chk("R7 unexpected back-end transfer", {16'h0, cap_a}, 32'hFFFF_FFFF);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            chk("R1 direction", {31'h0, cap_w}, {31'h0, e.w});
                            chk("R1 byte address", {16'h0, cap_a}, {16'h0, e.a});
                            if (e.w) chk("R1 write data", {16'h0, cap_d}, {16'h0, e.d});
                        end
                        cnt = done_dly; ph = 2;
                    end else cnt--;
                end
                default: begin
                    if (cnt == 0) begin
                        be_done = 1'b1;
                        if (cap_w) dev_mem[cap_a[8:1]] = cap_d;
                        be_rdata = dev_mem[cap_a[8:1]];
                        ph = 0;
                    end else cnt--;
                end
            endcase
        end
    end

    task automatic hwrite(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_sel = sel; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] sel, output logic [31:0] v);
        host_rd_sel = sel;
        #1;
        v = host_rd_data;
    endtask

    task automatic issue(input bit w, input logic [14:0] idx, input logic [15:0] d);
        exp_t e;
        e.w = w; e.a = {idx, 1'b0}; e.d = d;
        exp_q.push_back(e);
        if (w) ref_mem[idx[7:0]] = d;
        hwrite(2'd0, {w, idx, d});
    endtask

    task automatic wait_state(input logic [2:0] st, input string tag, output bit saw6);
        logic [31:0] v;
        bit ok = 0;
        saw6 = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            peek(2'd1, v);
            if (v[18:16] == 3'd6) saw6 = 1;
            if (v[18:16] == st) begin ok = 1; break; end
        end
        chk(tag, {31'h0, ok}, 32'h1);
    endtask

    initial begin : main
        logic [31:0] v;
        bit s6;
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = 16'(i * 16'h0101) ^ 16'h3C96;
            ref_mem[i] = 16'(i * 16'h0101) ^ 16'h3C96;
        end
        rst_n = 0; chan_en = 1; be_idle = 1; host_wr_en = 0;
        host_wr_sel = 0; host_wr_data = 0; host_rd_sel = 1;
        be_gnt = 0; be_done = 0; be_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        peek(2'd1, v); chk("R3 reset status word", v, 32'h0010_0000);
        peek(2'd3, v); chk("R3 reset control word", v, 32'h0);
        peek(2'd0, v); chk("R2 command offset reads zero", v, 32'h0);

        hwrite(2'd3, 32'h1);
        peek(2'd1, v); chk("R9 init-done status bit21", {31'h0, v[21]}, 32'h1);
        peek(2'd3, v); chk("R9 control readback", v, 32'h1);
        be_idle = 0;
        peek(2'd1, v); chk("R2 back-end idle bit20 low", {31'h0, v[20]}, 32'h0);
        be_idle = 1;
        peek(2'd1, v); chk("R2 back-end idle bit20 high", {31'h0, v[20]}, 32'h1);

        // write transfer
        issue(1'b1, 15'h0005, 16'hA55A);
        peek(2'd1, v); chk("R4 request state code", {29'h0, v[18:16]}, 32'd2);
        chk("R4 be_req in request", {31'h0, be_req}, 32'h1);
        wait_state(3'd4, "R4 reaches wait-for-data", s6);
        wait_state(3'd0, "R5 write returns idle", s6);
        chk("R5 write never parks", {31'h0, s6}, 32'h0);

        // read back, park, clear
        issue(1'b0, 15'h0005, 16'h0);
        wait_state(3'd6, "R6 read parks", s6);
        peek(2'd1, v); chk("R6 read data", {16'h0, v[15:0]}, {16'h0, ref_mem[5]});
        repeat (4) @(negedge clk);
        peek(2'd1, v); chk("R6 still parked", {29'h0, v[18:16]}, 32'd6);
        hwrite(2'd2, 32'h0);
        peek(2'd1, v); chk("R6 clear with bit0=0 ignored", {29'h0, v[18:16]}, 32'd6);
        hwrite(2'd2, 32'h1);
        peek(2'd1, v); chk("R6 clear releases to idle", {29'h0, v[18:16]}, 32'd0);
        chk("R2 read data held after clear", {16'h0, v[15:0]}, {16'h0, ref_mem[5]});

        // highest index
        issue(1'b0, 15'h7FFF, 16'h0);
        wait_state(3'd6, "R1 top index read parks", s6);
        peek(2'd1, v); chk("R1 top index read data", {16'h0, v[15:0]}, {16'h0, ref_mem[8'hFF]});
        hwrite(2'd2, 32'h1);

        // disabled channel
        chan_en = 0;
        hwrite(2'd0, {1'b1, 15'h0003, 16'h1234});
        peek(2'd1, v); chk("R8 disabled command stays idle", {29'h0, v[18:16]}, 32'd0);
        chk("R8 no error when disabled", {31'h0, v[22]}, 32'h0);
        chk("R8 no request when disabled", {31'h0, be_req}, 32'h0);
        repeat (5) @(negedge clk);
        peek(2'd1, v); chk("R8 still idle later", {29'h0, v[18:16]}, 32'd0);
        chan_en = 1;

        hwrite(2'd2, 32'h1);
        peek(2'd1, v); chk("R6 clear in idle no effect", {29'h0, v[18:16]}, 32'd0);

        // collision during wait-for-data
        done_dly = 20;
        issue(1'b1, 15'h0009, 16'h0F0F);
        wait_state(3'd4, "R7 slow write in flight", s6);
        hwrite(2'd0, {1'b1, 15'h000A, 16'hDEAD});
        peek(2'd1, v); chk("R7 in-flight state kept", {29'h0, v[18:16]}, 32'd4);
        chk("R7 error set on drop", {31'h0, v[22]}, 32'h1);
        chk("R7 in-flight address kept", {16'h0, be_addr}, 32'h0012);
        wait_state(3'd0, "R7 slow write completes", s6);
        peek(2'd1, v); chk("R7 error sticky", {31'h0, v[22]}, 32'h1);
        hwrite(2'd3, 32'h3);
        peek(2'd1, v); chk("R7 error cleared", {31'h0, v[22]}, 32'h0);
        chk("R9 init kept on clear", {31'h0, v[21]}, 32'h1);
        done_dly = 2;
        issue(1'b0, 15'h0009, 16'h0);
        wait_state(3'd6, "R7 readback parks", s6);
        peek(2'd1, v); chk("R7 first write landed", {16'h0, v[15:0]}, 32'h0F0F);
        hwrite(2'd2, 32'h1);
        issue(1'b0, 15'h000A, 16'h0);
        wait_state(3'd6, "R7 dropped target parks", s6);
        peek(2'd1, v); chk("R7 dropped write absent", {16'h0, v[15:0]}, {16'h0, ref_mem[8'h0A]});

        // collision while parked
        hwrite(2'd0, {1'b0, 15'h0003, 16'h0});
        peek(2'd1, v); chk("R7 parked state kept", {29'h0, v[18:16]}, 32'd6);
        chk("R7 error set while parked", {31'h0, v[22]}, 32'h1);
        hwrite(2'd2, 32'h1);
        hwrite(2'd3, 32'h2);
        peek(2'd3, v); chk("R9 clear init and error", v, 32'h0);
        peek(2'd1, v); chk("R9 init-done bit21 low", {31'h0, v[21]}, 32'h0);

        repeat (10) @(negedge clk);
        chk("R1 scoreboard drained", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule